// File: doc/BRIEF.md
# Per-CPU Interrupt Acknowledge Interface

This block sits between an interrupt distributor and one processor core. Every cycle the distributor offers one candidate: an interrupt ID, a priority value and a flag that marks it level-sensitive. The interface decides whether that candidate may interrupt the core. It does so only when signalling is enabled, the ID is deliverable, and the priority value is numerically below a programmable mask. It also refuses an ID that the core is already servicing. When all of these hold, it drives a registered interrupt line to the core.

Software works the block through a small word-addressed register bus with four registers:

- a control register, whose bit 0 enables signalling;
- a priority-mask register;
- an acknowledge register, which is read-only and has side effects;
- an end-of-interrupt register, which is write-only.

Reading the acknowledge register returns the ID of the deliverable candidate and records that ID as active. In the same cycle the block pulses a handshake that tells the distributor to move the interrupt from pending to active. When nothing is deliverable, the read returns the reserved spurious ID 1023 and has no side effect. Writing an ID to the end-of-interrupt register retires that ID: if it is active, the block frees it and forwards it to the distributor.

The active set is a small list, a few entries deep, which allows nested handling. While the list is full, nothing new is signalled.

Top module: `icpu_ack_if`

## Requirements
- R1: After reset, irq_out, dist_ack and dist_eoi are 0, the control register reads 0 and the priority-mask register reads 0.
- R2: irq_out is registered. It is 1 in the cycle after one in which all of the following hold: control bit 0 is set, cand_vld is 1, cand_id is at most 1019, cand_pri is strictly less than the mask, cand_id is not active, and the active list is not full. It is 0 otherwise.
- R3: Bus addresses are 0 for control, 1 for mask, 2 for acknowledge and 3 for end-of-interrupt. A read returns bus_rdata with bus_rvalid high one cycle after the request. A successful acknowledge read returns the candidate ID in bits 9:0, with all higher bits 0.
- R4: An acknowledge read while no candidate is deliverable returns 1023 and produces no dist_ack pulse.
- R5: Candidate IDs 1020 to 1022 are never signalled and never acknowledged. ID 1019 is delivered normally.
- R6: A successful acknowledge read pulses dist_ack for one cycle, alongside bus_rvalid. dist_ack_id carries the ID, and dist_ack_keep_pend equals cand_level: 1 means the interrupt stays pending, 0 means it is cleared.
- R7: Writing the ID of an active interrupt to the end-of-interrupt register pulses dist_eoi for one cycle with dist_eoi_id equal to that ID, and frees the ID.
- R8: An end-of-interrupt write naming an ID that is not active produces no dist_eoi pulse and leaves the active set unchanged.
- R9: While an ID is active, a candidate carrying that ID is neither signalled nor acknowledged until its end-of-interrupt.
- R10: The active list holds ACT_DEPTH IDs (default 4). While it is full, irq_out stays 0 and acknowledge reads return 1023.
- R11: The control register holds and reads back bit 0 only. The mask register holds and reads back the low PRI_W bits (default 8).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid |
| cand_vld | input | 1 | Distributor offers a candidate |
| cand_id | input | 10 | Candidate interrupt ID |
| cand_pri | input | 8 | Candidate priority value (lower is more urgent) |
| cand_level | input | 1 | Candidate is level-sensitive |
| irq_out | output | 1 | Interrupt request to the core |
| dist_ack | output | 1 | Pulse: move dist_ack_id from pending to active |
| dist_ack_id | output | 10 | ID being acknowledged |
| dist_ack_keep_pend | output | 1 | Keep the pending bit (level source) |
| dist_eoi | output | 1 | Pulse: retire dist_eoi_id |
| dist_eoi_id | output | 10 | ID being retired |

## Verification
The assertions assume the distributor offers each ID at most once in the active list, so an ID is never pushed twice. They also assume the bus carries at most one access per cycle. The stimulus meets the first assumption by always retiring an ID before it offers that ID again. It meets the second because every bus transfer is a single-cycle task that drops bus_sel before the next access. Candidate inputs change only on falling edges and are held steady across every acknowledge read. This keeps the returned ID and the handshake ID taken from the same candidate.

// File: rtl/icpu_pkg.sv
package icpu_pkg;
  localparam int ID_W = 10;
  localparam logic [ID_W-1:0] SPURIOUS_ID = 10'd1023;
  localparam logic [ID_W-1:0] LAST_VALID_ID = 10'd1019;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_CTRL  = 3'd0,
    RA_PMASK = 3'd1,
    RA_ACK   = 3'd2,
    RA_EOI   = 3'd3
  } reg_addr_e;
endpackage

// File: rtl/icpu_regs.sv
module icpu_regs
  import icpu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PRI_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              en_q,
  output logic [PRI_W-1:0]  pmask_q,
  output logic              ack_rd,
  output logic              eoi_wr,
  output logic [ID_W-1:0]   eoi_id
);
  logic unused_wdata;
  assign unused_wdata = ^wdata[DATA_W-1:ID_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      pmask_q <= '0;
    end else if (sel && wr) begin
      if (addr == RA_CTRL)  en_q    <= wdata[0];
      if (addr == RA_PMASK) pmask_q <= wdata[PRI_W-1:0];
    end
  end

  assign ack_rd = sel && !wr && (addr == RA_ACK);
  assign eoi_wr = sel && wr && (addr == RA_EOI);
  assign eoi_id = wdata[ID_W-1:0];
endmodule

// File: rtl/icpu_active.sv
module icpu_active
  import icpu_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            push,
  input  logic [ID_W-1:0] push_id,
  input  logic            pop_req,
  input  logic [ID_W-1:0] pop_id,
  input  logic [ID_W-1:0] probe_id,
  output logic            probe_hit,
  output logic            pop_hit,
  output logic            full,
  output logic [CNT_W-1:0] cnt
);
  logic [DEPTH-1:0] vld;
  logic [ID_W-1:0]  ids [DEPTH];
  logic [DEPTH-1:0] hit_probe, hit_pop, free_sel;
  logic             found;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    assign hit_probe[g] = vld[g] && (ids[g] == probe_id);
    assign hit_pop[g]   = vld[g] && (ids[g] == pop_id);
  end

  always_comb begin
    free_sel = '0;
    found    = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!vld[i] && !found) begin
        free_sel[i] = 1'b1;
        found       = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (push && free_sel[i]) begin
          vld[i] <= 1'b1;
          ids[i] <= push_id;
        end else if (pop_req && hit_pop[i]) begin
          vld[i] <= 1'b0;
        end
      end
    end
  end

  assign probe_hit = |hit_probe;
  assign pop_hit   = pop_req && (|hit_pop);
  assign cnt       = CNT_W'($countones(vld));
  assign full      = &vld;
endmodule

// File: rtl/icpu_select.sv
module icpu_select
  import icpu_pkg::*;
#(
  parameter int PRI_W = 8
) (
  input  logic             en,
  input  logic [PRI_W-1:0] pmask,
  input  logic             cand_vld,
  input  logic [ID_W-1:0]  cand_id,
  input  logic [PRI_W-1:0] cand_pri,
  input  logic             already_active,
  input  logic             list_full,
  output logic             deliver
);
  logic id_ok, pri_ok;

  assign id_ok   = cand_id <= LAST_VALID_ID;
  assign pri_ok  = cand_pri < pmask;
  assign deliver = en && cand_vld && id_ok && pri_ok && !already_active && !list_full;
endmodule

// File: rtl/icpu_ack_if.sv
module icpu_ack_if
  import icpu_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int PRI_W     = 8,
  parameter int ACT_DEPTH = 4,
  localparam int CNT_W = $clog2(ACT_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  input  logic              cand_vld,
  input  logic [ID_W-1:0]   cand_id,
  input  logic [PRI_W-1:0]  cand_pri,
  input  logic              cand_level,
  output logic              irq_out,
  output logic              dist_ack,
  output logic [ID_W-1:0]   dist_ack_id,
  output logic              dist_ack_keep_pend,
  output logic              dist_eoi,
  output logic [ID_W-1:0]   dist_eoi_id
);
  logic             en_q;
  logic [PRI_W-1:0] pmask_q;
  logic             ack_rd, eoi_wr;
  logic [ID_W-1:0]  eoi_id;
  logic             in_active, pop_hit, list_full, deliver, push;
  logic [CNT_W-1:0] act_cnt;

  icpu_regs #(.DATA_W(DATA_W), .PRI_W(PRI_W)) u_regs (
    .clk(clk), .rst(rst), .sel(bus_sel), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .en_q(en_q), .pmask_q(pmask_q),
    .ack_rd(ack_rd), .eoi_wr(eoi_wr), .eoi_id(eoi_id)
  );

  icpu_active #(.DEPTH(ACT_DEPTH)) u_active (
    .clk(clk), .rst(rst), .push(push), .push_id(cand_id),
    .pop_req(eoi_wr), .pop_id(eoi_id), .probe_id(cand_id),
    .probe_hit(in_active), .pop_hit(pop_hit), .full(list_full), .cnt(act_cnt)
  );

  icpu_select #(.PRI_W(PRI_W)) u_sel (
    .en(en_q), .pmask(pmask_q), .cand_vld(cand_vld), .cand_id(cand_id),
    .cand_pri(cand_pri), .already_active(in_active), .list_full(list_full),
    .deliver(deliver)
  );

  assign push = ack_rd && deliver;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_out            <= 1'b0;
      bus_rvalid         <= 1'b0;
      bus_rdata          <= '0;
      dist_ack           <= 1'b0;
      dist_ack_id        <= '0;
      dist_ack_keep_pend <= 1'b0;
      dist_eoi           <= 1'b0;
      dist_eoi_id        <= '0;
    end else begin
      irq_out    <= deliver;
      bus_rvalid <= bus_sel && !bus_wr;
      if (bus_sel && !bus_wr) begin
        case (bus_addr)
          RA_CTRL:  bus_rdata <= DATA_W'(en_q);
          RA_PMASK: bus_rdata <= DATA_W'(pmask_q);
          RA_ACK:   bus_rdata <= DATA_W'(deliver ? cand_id : SPURIOUS_ID);
          default:  bus_rdata <= '0;
        endcase
      end
      dist_ack <= push;
      if (push) begin
        dist_ack_id        <= cand_id;
        dist_ack_keep_pend <= cand_level;
      end
      dist_eoi <= pop_hit;
      if (pop_hit) dist_eoi_id <= eoi_id;
    end
  end
endmodule

// File: rtl/icpu_ack_if_chk.sv
module icpu_ack_if_chk
  import icpu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PRI_W  = 8,
  parameter int DEPTH  = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              bus_rvalid,
  input logic [PRI_W-1:0]  cand_pri,
  input logic              irq_out,
  input logic              dist_ack,
  input logic [ID_W-1:0]   dist_ack_id,
  input logic              dist_eoi,
  input logic              en_q,
  input logic [PRI_W-1:0]  pmask_q,
  input logic [CNT_W-1:0]  act_cnt
);
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> $past(en_q && (cand_pri < pmask_q))); // R2
  AST_ACK_DATA: assert property (@(posedge clk) disable iff (rst)
    dist_ack |-> (bus_rvalid && bus_rdata[ID_W-1:0] == dist_ack_id)); // R3
  AST_SPUR_NO_ACK: assert property (@(posedge clk) disable iff (rst)
    (bus_rvalid && bus_rdata[ID_W-1:0] == SPURIOUS_ID) |-> !dist_ack); // R4
  AST_ACK_ID_RANGE: assert property (@(posedge clk) disable iff (rst)
    dist_ack |-> (dist_ack_id <= LAST_VALID_ID)); // R5
  AST_EOI_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
    dist_eoi |-> $past(bus_sel && bus_wr && bus_addr == RA_EOI)); // R7
  AST_ONE_HANDSHAKE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({dist_ack, dist_eoi})); // R6
  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (act_cnt == CNT_W'(DEPTH)) |=> !irq_out); // R10
endmodule

bind icpu_ack_if icpu_ack_if_chk #(.DATA_W(DATA_W), .PRI_W(PRI_W), .DEPTH(ACT_DEPTH)) u_chk (
  .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .cand_pri(cand_pri),
  .irq_out(irq_out), .dist_ack(dist_ack), .dist_ack_id(dist_ack_id),
  .dist_eoi(dist_eoi), .en_q(en_q), .pmask_q(pmask_q), .act_cnt(act_cnt)
);

// File: tb/tb_icpu_ack_if.sv
module tb_icpu_ack_if;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        cand_vld = 1'b0;
  logic [9:0]  cand_id = '0;
  logic [7:0]  cand_pri = '0;
  logic        cand_level = 1'b0;
  logic        irq_out, dist_ack, dist_ack_keep_pend, dist_eoi;
  logic [9:0]  dist_ack_id, dist_eoi_id;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  icpu_ack_if dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .cand_vld(cand_vld), .cand_id(cand_id), .cand_pri(cand_pri), .cand_level(cand_level),
    .irq_out(irq_out), .dist_ack(dist_ack), .dist_ack_id(dist_ack_id),
    .dist_ack_keep_pend(dist_ack_keep_pend), .dist_eoi(dist_eoi), .dist_eoi_id(dist_eoi_id)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d, output logic ack,
                    output logic [9:0] aid, output logic keep);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata; ack = dist_ack; aid = dist_ack_id; keep = dist_ack_keep_pend;
    check(bus_rvalid === 1'b1, "R3 rvalid", 32'(bus_rvalid), 1);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d, output logic eoi, output logic [9:0] eid);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    eoi = dist_eoi; eid = dist_eoi_id;
  endtask

  task automatic cand(input logic v, input logic [9:0] id, input logic [7:0] p, input logic lv);
    @(negedge clk);
    cand_vld = v; cand_id = id; cand_pri = p; cand_level = lv;
    @(negedge clk);
  endtask

  task automatic test_reset();
    logic [31:0] d; logic a, k; logic [9:0] i;
    check(irq_out === 1'b0 && dist_ack === 1'b0 && dist_eoi === 1'b0, "R1 outputs",
          32'({irq_out, dist_ack, dist_eoi}), 0);
    rd(3'd0, d, a, i, k); check(d === 32'd0, "R1 ctrl", d, 0);
    rd(3'd1, d, a, i, k); check(d === 32'd0, "R1 pmask", d, 0);
    rd(3'd2, d, a, i, k); check(d === 32'd1023 && !a, "R4 ack idle", d, 1023);
  endtask

  task automatic test_mask();
    logic e; logic [9:0] ei;
    wr(3'd1, 32'hF0, e, ei);
    wr(3'd0, 32'h1, e, ei);
    cand(1, 10'd40, 8'hA0, 0); check(irq_out === 1'b1, "R2 below mask", 32'(irq_out), 1);
    cand(1, 10'd40, 8'hF0, 0); check(irq_out === 1'b0, "R2 equal mask", 32'(irq_out), 0);
    cand(1, 10'd40, 8'hEF, 0); check(irq_out === 1'b1, "R2 one below", 32'(irq_out), 1);
    cand(0, 10'd40, 8'hA0, 0); check(irq_out === 1'b0, "R2 no candidate", 32'(irq_out), 0);
    cand(1, 10'd40, 8'hA0, 0);
    wr(3'd0, 32'h0, e, ei); @(negedge clk);
    check(irq_out === 1'b0, "R2 disabled", 32'(irq_out), 0);
    wr(3'd0, 32'h1, e, ei); @(negedge clk);
    check(irq_out === 1'b1, "R2 re-enabled", 32'(irq_out), 1);
  endtask

  task automatic test_ack_eoi();
    logic [31:0] d; logic a, k, e; logic [9:0] i, ei;
    cand(1, 10'd40, 8'hA0, 0);
    rd(3'd2, d, a, i, k);
    check(d === 32'd40, "R3 ack id", d, 40);
    check(a === 1'b1 && i === 10'd40 && k === 1'b0, "R6 ack edge", {a, k, 20'd0, i}, 32'h8000_0028);
    @(negedge clk); check(irq_out === 1'b0, "R9 active not offered", 32'(irq_out), 0);
    rd(3'd2, d, a, i, k); check(d === 32'd1023 && !a, "R9 ack while active", d, 1023);
    wr(3'd3, 32'd41, e, ei); check(e === 1'b0, "R8 eoi not active", 32'(e), 0);
    @(negedge clk); check(irq_out === 1'b0, "R8 state kept", 32'(irq_out), 0);
    wr(3'd3, 32'd40, e, ei); check(e === 1'b1 && ei === 10'd40, "R7 eoi", 32'(ei), 40);
    @(negedge clk); check(irq_out === 1'b1, "R7 freed", 32'(irq_out), 1);
  endtask

  task automatic test_level();
    logic [31:0] d; logic a, k, e; logic [9:0] i, ei;
    cand(1, 10'd77, 8'h10, 1);
    rd(3'd2, d, a, i, k);
    check(a === 1'b1 && i === 10'd77 && k === 1'b1, "R6 level keep", 32'(k), 1);
    wr(3'd3, 32'd77, e, ei); check(e === 1'b1 && ei === 10'd77, "R7 eoi level", 32'(ei), 77);
  endtask

  task automatic test_reserved();
    logic [31:0] d; logic a, k, e; logic [9:0] i, ei;
    for (int r = 1020; r <= 1022; r++) begin
      cand(1, 10'(r), 8'h00, 0);
      check(irq_out === 1'b0, "R5 reserved irq", 32'(irq_out), 0);
      rd(3'd2, d, a, i, k);
      check(d === 32'd1023 && !a, "R5 reserved ack", d, 1023);
    end
    cand(1, 10'd1019, 8'h00, 0);
    check(irq_out === 1'b1, "R5 last valid irq", 32'(irq_out), 1);
    rd(3'd2, d, a, i, k); check(d === 32'd1019 && a, "R5 last valid ack", d, 1019);
    wr(3'd3, 32'd1019, e, ei);
  endtask

  task automatic test_full();
    logic [31:0] d; logic a, k, e; logic [9:0] i, ei;
    for (int n = 0; n < 4; n++) begin
      cand(1, 10'(100 + n), 8'h20, 0);
      rd(3'd2, d, a, i, k);
      check(d === 32'(100 + n), "R10 fill", d, 32'(100 + n));
    end
    cand(1, 10'd104, 8'h20, 0);
    check(irq_out === 1'b0, "R10 full no irq", 32'(irq_out), 0);
    rd(3'd2, d, a, i, k); check(d === 32'd1023 && !a, "R10 full ack", d, 1023);
    wr(3'd3, 32'd101, e, ei); @(negedge clk);
    check(irq_out === 1'b1, "R10 slot freed", 32'(irq_out), 1);
    for (int n = 0; n < 4; n++) if (n != 1) wr(3'd3, 32'(100 + n), e, ei);
  endtask

  task automatic test_regs();
    logic [31:0] d; logic a, k, e; logic [9:0] i, ei;
    wr(3'd1, 32'h1A5, e, ei); rd(3'd1, d, a, i, k);
    check(d === 32'hA5, "R11 mask width", d, 32'hA5);
    wr(3'd0, 32'h3, e, ei); rd(3'd0, d, a, i, k);
    check(d === 32'h1, "R11 ctrl bit0", d, 1);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    test_reset();
    test_mask();
    test_ack_eoi();
    test_level();
    test_reserved();
    test_full();
    test_regs();
    finish_run();
  end
endmodule